// File: doc/BRIEF.md
# Dual-Port Burst-Addressed Synchronous RAM

This block is a synchronous static RAM with two equal ports, A and B. Each port can read or write any word in the array on every clock cycle, and both ports can use the same word in the same cycle. Each port registers its address, controls and write data on the rising clock edge. Each port also has its own burst address counter. The counter can load a new address, step one word forward, hold its value or return to zero, so a port can stream through the array without a new address on every cycle. A shared mode pin chooses how soon read data appears. In flow-through mode, data appears in the cycle after the edge that captured the address. In pipelined mode, the data passes through one more output register and appears one cycle later.

Two chip selects of opposite polarity gate each port. A port that is not selected does no access, and its read outputs go quiet. The ports have no back-pressure and no ready signal. A port accepts a command on every clock edge. `*_rvalid` marks each cycle in which `*_rdata` carries a read result, and it is the only qualifier on that data. Both ports run on one shared clock. The array depth is 2^ADDR_W words: ADDR_W = 13 gives 8K words and 14 gives 16K words. The default of 10 keeps elaboration light.

Top module: `dpram_burst`

## Requirements
- R1: Both ports run independently in the same cycle. One port can read words that the other port wrote.
- R2: In flow-through mode (`pipe_mode` = 0), a selected read captured at clock edge k drives `rvalid` = 1 and the word at the internal address from edge k until edge k+1. A write cycle drives `rvalid` = 0.
- R3: In pipelined mode (`pipe_mode` = 1), the same read result appears one cycle later, from edge k+1 until edge k+2.
- R4: When `load` = 1 and `clear` = 0 at an edge, the port's internal address takes the value on its `addr` pin. A write in that cycle goes to this address.
- R5: When `step` = 1, `load` = 0 and `clear` = 0, the internal address increases by one, and the `addr` pin is ignored.
- R6: A step from address 2^ADDR_W−1 wraps the internal address to 0.
- R7: Counter priority is clear, then load, then step, then hold. `clear` = 1 forces address 0 even when `load` = 1. With all three at 0, the address holds.
- R8: A port is selected only when `cs_n` = 0 and `cs` = 1. An unselected cycle writes nothing and gives `rvalid` = 0 and `rdata` = 0. Its counter still follows `clear`, `load` and `step`.
- R9: In pipelined mode, after unselected cycles, the first selected read appears one cycle after the cycle that captured it. The cycle in between shows `rvalid` = 0.
- R10: When both ports write the same word in the same cycle, the word keeps port A's data.
- R11: A read captured in the same cycle as the other port's write to the same word returns the old contents. A read in the following cycle returns the new data.
- R12: `oe_n` = 1 forces `rvalid` = 0 and `rdata` = 0 without stopping the access.
- R13: While `rst_n` = 0, both counters clear to 0 and both `rvalid` outputs are 0. The array contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low asynchronous reset |
| pipe_mode | input | 1 | 0 selects flow-through output, 1 selects pipelined output |
| a_cs_n | input | 1 | Port A select, active low |
| a_cs | input | 1 | Port A select, active high |
| a_wr_n | input | 1 | Port A write enable, active low |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_load | input | 1 | Port A counter load from a_addr |
| a_step | input | 1 | Port A counter increment |
| a_clear | input | 1 | Port A counter clear to 0 |
| a_addr | input | ADDR_W | Port A external address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data, 0 when not valid |
| a_rvalid | output | 1 | Port A read data valid |
| b_cs_n | input | 1 | Port B select, active low |
| b_cs | input | 1 | Port B select, active high |
| b_wr_n | input | 1 | Port B write enable, active low |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_load | input | 1 | Port B counter load from b_addr |
| b_step | input | 1 | Port B counter increment |
| b_clear | input | 1 | Port B counter clear to 0 |
| b_addr | input | ADDR_W | Port B external address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data, 0 when not valid |
| b_rvalid | output | 1 | Port B read data valid |

## Verification
The assertions check the following on every cycle:
- the counter priority, the load and the wrap at the top address;
- that an unselected port never writes;
- that an unselected port and a write cycle keep `rvalid` low at the expected latency;
- that port A wins a same-word write collision.

Only the bench scenarios can show that the data read back is the data written. They also show that the two latencies line up with the captured address and that the gap after reselection in pipelined mode is exactly one cycle. The old-versus-new result of a read that meets a write on the other port is likewise checked only by the bench.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

  typedef enum logic {
    OUT_FLOW = 1'b0,
    OUT_PIPE = 1'b1
  } out_mode_e;

  typedef struct packed {
    logic clear;
    logic load;
    logic step;
  } ctr_cmd_t;

  localparam int NPORTS = 2;

endpackage

// File: rtl/dpram_burst_ctr.sv
module dpram_burst_ctr
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctr_cmd_t          cmd,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] addr
);

  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] addr_q;

  // priority: clear, load, step, hold
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (cmd.clear) begin
      addr_q <= '0;
    end else if (cmd.load) begin
      addr_q <= ext_addr;
    end else if (cmd.step) begin
      addr_q <= addr_q + ADDR_W'(1);
    end
  end

  assign addr = addr_q;

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.clear |=> addr_q == '0);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd.clear && !cmd.load && !cmd.step) |=> $stable(addr_q));

  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd.clear && cmd.load) |=> addr_q == $past(ext_addr));

  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd.clear && !cmd.load && cmd.step && addr_q != TOP_ADDR)
      |=> addr_q == $past(addr_q) + ADDR_W'(1));

  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd.clear && !cmd.load && cmd.step && addr_q == TOP_ADDR) |=> addr_q == '0);

endmodule

// File: rtl/dpram_port.sv
module dpram_port
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic              cs_n,
  input  logic              cs,
  input  logic              wr_n,
  input  logic              oe_n,
  input  ctr_cmd_t          cmd,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  logic              sel_in;
  logic              sel_q;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              rd_now;
  logic              pvld_q;
  logic [DATA_W-1:0] pdata_q;
  logic              vld_int;
  logic [DATA_W-1:0] data_int;
  out_mode_e         mode;

  assign sel_in = ~cs_n & cs;
  assign mode   = out_mode_e'(pipe_mode);

  dpram_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .ext_addr (ext_addr),
    .addr     (mem_addr)
  );

  // input capture stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      sel_q   <= sel_in;
      wr_q    <= ~wr_n;
      wdata_q <= wdata;
    end
  end

  assign mem_we    = sel_q & wr_q;
  assign mem_wdata = wdata_q;
  assign rd_now    = sel_q & ~wr_q;

  // extra output stage for pipelined timing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pvld_q  <= 1'b0;
      pdata_q <= '0;
    end else begin
      pvld_q  <= rd_now;
      pdata_q <= mem_rdata;
    end
  end

  always_comb begin
    if (mode == OUT_PIPE) begin
      vld_int  = pvld_q;
      data_int = pdata_q;
    end else begin
      vld_int  = rd_now;
      data_int = mem_rdata;
    end
  end

  assign rvalid = vld_int & ~oe_n;
  assign rdata  = rvalid ? data_int : '0;

  assert_desel_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_in |=> !mem_we);

  assert_flow_desel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_in && !pipe_mode) |=> (pipe_mode || !rvalid));

  assert_write_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_in && !wr_n && !pipe_mode) |=> (pipe_mode || !rvalid));

  assert_pipe_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && !sel_in) |=> ##1 (!pipe_mode || !rvalid));

endmodule

// File: rtl/dpram_store.sv
module dpram_store #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_we,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_we,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              collide;

  assign collide = a_we && b_we && (a_addr == b_addr);

  // port A wins a same-word collision
  always_ff @(posedge clk) begin
    if (b_we && !collide) mem[b_addr] <= b_wdata;
    if (a_we)             mem[a_addr] <= a_wdata;
  end

  assign a_rdata = mem[a_addr];
  assign b_rdata = mem[b_addr];

  assert_a_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> mem[$past(a_addr)] == $past(a_wdata));

  assert_b_writes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (b_we && !(a_we && a_addr == b_addr)) |=> mem[$past(b_addr)] == $past(b_wdata));

endmodule

// File: rtl/dpram_burst.sv
module dpram_burst
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic              a_cs_n,
  input  logic              a_cs,
  input  logic              a_wr_n,
  input  logic              a_oe_n,
  input  logic              a_load,
  input  logic              a_step,
  input  logic              a_clear,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_rvalid,
  input  logic              b_cs_n,
  input  logic              b_cs,
  input  logic              b_wr_n,
  input  logic              b_oe_n,
  input  logic              b_load,
  input  logic              b_step,
  input  logic              b_clear,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_rvalid
);

  logic [NPORTS-1:0] cs_n_v, cs_v, wr_n_v, oe_n_v, we_v, rvalid_v;
  ctr_cmd_t          cmd_v   [NPORTS];
  logic [ADDR_W-1:0] ext_v   [NPORTS];
  logic [ADDR_W-1:0] iaddr_v [NPORTS];
  logic [DATA_W-1:0] wd_v    [NPORTS];
  logic [DATA_W-1:0] mwd_v   [NPORTS];
  logic [DATA_W-1:0] mrd_v   [NPORTS];
  logic [DATA_W-1:0] rd_v    [NPORTS];

  assign cs_n_v = {b_cs_n, a_cs_n};
  assign cs_v   = {b_cs,   a_cs};
  assign wr_n_v = {b_wr_n, a_wr_n};
  assign oe_n_v = {b_oe_n, a_oe_n};
  assign cmd_v[0] = '{clear: a_clear, load: a_load, step: a_step};
  assign cmd_v[1] = '{clear: b_clear, load: b_load, step: b_step};
  assign ext_v[0] = a_addr;
  assign ext_v[1] = b_addr;
  assign wd_v[0]  = a_wdata;
  assign wd_v[1]  = b_wdata;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    dpram_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .pipe_mode (pipe_mode),
      .cs_n      (cs_n_v[p]),
      .cs        (cs_v[p]),
      .wr_n      (wr_n_v[p]),
      .oe_n      (oe_n_v[p]),
      .cmd       (cmd_v[p]),
      .ext_addr  (ext_v[p]),
      .wdata     (wd_v[p]),
      .mem_addr  (iaddr_v[p]),
      .mem_we    (we_v[p]),
      .mem_wdata (mwd_v[p]),
      .mem_rdata (mrd_v[p]),
      .rdata     (rd_v[p]),
      .rvalid    (rvalid_v[p])
    );
  end

  dpram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_addr  (iaddr_v[0]),
    .a_we    (we_v[0]),
    .a_wdata (mwd_v[0]),
    .a_rdata (mrd_v[0]),
    .b_addr  (iaddr_v[1]),
    .b_we    (we_v[1]),
    .b_wdata (mwd_v[1]),
    .b_rdata (mrd_v[1])
  );

  assign a_rdata  = rd_v[0];
  assign a_rvalid = rvalid_v[0];
  assign b_rdata  = rd_v[1];
  assign b_rvalid = rvalid_v[1];

endmodule

// File: tb/dpram_burst_test.sv
module dpram_burst_test;

  localparam int AW = 10;
  localparam int DW = 9;

  typedef struct {
    logic cs_n, cs, wr_n, oe_n, load, step, clear;
    logic [AW-1:0] addr;
    logic [DW-1:0] wd;
  } pin_t;

  typedef struct {
    int            due;
    int            port;
    logic          vld;
    logic [DW-1:0] data;
    string         tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pipe_mode = 1'b0;
  logic a_cs_n, a_cs, a_wr_n, a_oe_n, a_load, a_step, a_clear;
  logic b_cs_n, b_cs, b_wr_n, b_oe_n, b_load, b_step, b_clear;
  logic [AW-1:0] a_addr, b_addr;
  logic [DW-1:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic a_rvalid, b_rvalid;

  always #10 clk = ~clk;

  dpram_burst #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode),
    .a_cs_n(a_cs_n), .a_cs(a_cs), .a_wr_n(a_wr_n), .a_oe_n(a_oe_n),
    .a_load(a_load), .a_step(a_step), .a_clear(a_clear),
    .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata), .a_rvalid(a_rvalid),
    .b_cs_n(b_cs_n), .b_cs(b_cs), .b_wr_n(b_wr_n), .b_oe_n(b_oe_n),
    .b_load(b_load), .b_step(b_step), .b_clear(b_clear),
    .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_rvalid(b_rvalid)
  );

  int checks = 0;
  int failures = 0;
  int cyc_n = 0;
  bit chk = 1'b0;
  bit done = 1'b0;
  item_t q[$];

  // reference model state
  logic [DW-1:0] mem_m [1 << AW];
  logic [AW-1:0] ctr_m [2];
  bit            pw_en [2];
  logic [AW-1:0] pw_ad [2];
  logic [DW-1:0] pw_d  [2];

  function automatic pin_t idle();
    pin_t p;
    p.cs_n = 1'b1; p.cs = 1'b0; p.wr_n = 1'b1; p.oe_n = 1'b0;
    p.load = 1'b0; p.step = 1'b0; p.clear = 1'b0;
    p.addr = '0; p.wd = '0;
    return p;
  endfunction

  function automatic pin_t op(input bit w, input bit ld, input bit st, input int ad, input int d);
    pin_t p = idle();
    p.cs_n = 1'b0; p.cs = 1'b1; p.wr_n = !w;
    p.load = ld; p.step = st;
    p.addr = AW'(ad); p.wd = DW'(d);
    return p;
  endfunction

  task automatic apply(input pin_t pa, input pin_t pb);
    a_cs_n = pa.cs_n; a_cs = pa.cs; a_wr_n = pa.wr_n; a_oe_n = pa.oe_n;
    a_load = pa.load; a_step = pa.step; a_clear = pa.clear;
    a_addr = pa.addr; a_wdata = pa.wd;
    b_cs_n = pb.cs_n; b_cs = pb.cs; b_wr_n = pb.wr_n; b_oe_n = pb.oe_n;
    b_load = pb.load; b_step = pb.step; b_clear = pb.clear;
    b_addr = pb.addr; b_wdata = pb.wd;
  endtask

  // driver: drives one cycle and pushes the expected results
  task automatic drive(input pin_t pa, input pin_t pb, input string tag);
    pin_t p [2];
    @(negedge clk);
    apply(pa, pb);
    p[0] = pa; p[1] = pb;
    if (pw_en[1]) mem_m[pw_ad[1]] = pw_d[1];
    if (pw_en[0]) mem_m[pw_ad[0]] = pw_d[0];
    for (int i = 0; i < 2; i++) begin
      item_t it;
      bit sel;
      if (p[i].clear)     ctr_m[i] = '0;
      else if (p[i].load) ctr_m[i] = p[i].addr;
      else if (p[i].step) ctr_m[i] = ctr_m[i] + AW'(1);
      sel = !p[i].cs_n && p[i].cs;
      it.due  = cyc_n + 1 + (pipe_mode ? 1 : 0);
      it.port = i;
      it.vld  = sel && p[i].wr_n && !p[i].oe_n;
      it.data = it.vld ? mem_m[ctr_m[i]] : '0;
      it.tag  = tag;
      if (chk) q.push_back(it);
      pw_en[i] = sel && !p[i].wr_n;
      pw_ad[i] = ctr_m[i];
      pw_d[i]  = p[i].wd;
    end
  endtask

  task automatic set_mode(input logic m);
    chk = 1'b0;
    @(negedge clk);
    pipe_mode = m;
    repeat (3) drive(idle(), idle(), "");
    chk = 1'b1;
  endtask

  // monitor: compares outputs with queued expectations
  always @(posedge clk) begin
    #5;
    cyc_n++;
    while (q.size() > 0 && q[0].due < cyc_n) void'(q.pop_front());
    while (q.size() > 0 && q[0].due == cyc_n) begin
      item_t it;
      logic v;
      logic [DW-1:0] d;
      it = q.pop_front();
      v = (it.port == 0) ? a_rvalid : b_rvalid;
      d = (it.port == 0) ? a_rdata : b_rdata;
      checks++;
      if (v !== it.vld || d !== it.data) begin
        failures++;
        $display("FAIL %s port%0d cycle %0d: got vld=%0b data=%h, expected vld=%0b data=%h",
                 it.tag, it.port, cyc_n, v, d, it.vld, it.data);
      end
    end
  end

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got no completion, expected completion");
      report();
    end
  end

  initial begin
    pin_t pa;
    for (int i = 0; i < 2; i++) begin
      ctr_m[i] = '0; pw_en[i] = 1'b0; pw_ad[i] = '0; pw_d[i] = '0;
    end
    apply(idle(), idle());
    repeat (3) @(negedge clk);
    // R13: reset state
    checks++;
    if (a_rvalid !== 1'b0 || b_rvalid !== 1'b0 || a_rdata !== '0 || b_rdata !== '0) begin
      failures++;
      $display("FAIL R13: got vld=%0b/%0b, expected 0/0", a_rvalid, b_rvalid);
    end
    rst_n = 1'b1;
    chk = 1'b1;

    // R4 and R2: both ports fill words, write cycles stay silent
    for (int i = 0; i < 16; i++)
      drive(op(1, i == 0, i != 0, 0, 'h40 + i), op(1, i == 0, i != 0, 100, 'h80 + i), "R4");
    // R1 and R5: cross reads with garbage on the addr pins while stepping
    for (int i = 0; i < 16; i++)
      drive(op(0, i == 0, i != 0, (i == 0) ? 100 : (i * 37) % 1024, 0),
            op(0, i == 0, i != 0, (i == 0) ? 0 : (i * 53) % 1024, 0), "R5");
    // R6: wrap at the top address
    for (int i = 0; i < 4; i++)
      drive(op(1, i == 0, i != 0, 1022, 'h1F0 + i), idle(), "R6");
    for (int i = 0; i < 5; i++)
      drive(op(0, i == 0, i != 0, 1022, 0), idle(), "R6");
    // R7: hold, then clear beating load and step
    drive(op(0, 1, 0, 5, 0), idle(), "R7");
    drive(op(0, 0, 0, 777, 0), idle(), "R7");
    drive(op(0, 0, 0, 333, 0), idle(), "R7");
    pa = op(0, 1, 0, 9, 0); pa.clear = 1'b1;
    drive(pa, idle(), "R7");
    pa = op(0, 0, 1, 9, 0); pa.clear = 1'b1;
    drive(pa, idle(), "R7");
    // R8: unselected writes are dropped, unselected reads are silent
    pa = op(1, 1, 0, 3, 'h1AA); pa.cs_n = 1'b1;
    drive(pa, idle(), "R8");
    pa = op(1, 1, 0, 3, 'h1BB); pa.cs = 1'b0;
    drive(pa, idle(), "R8");
    drive(op(0, 1, 0, 3, 0), idle(), "R8");
    pa = op(0, 1, 0, 3, 0); pa.cs = 1'b0;
    drive(pa, idle(), "R8");
    // R12: output enable gating
    pa = op(0, 1, 0, 4, 0); pa.oe_n = 1'b1;
    drive(pa, idle(), "R12");
    drive(op(0, 0, 0, 0, 0), idle(), "R12");
    // R10: same-word collision, port A wins
    drive(op(1, 1, 0, 200, 'h111), op(1, 1, 0, 200, 'h0AA), "R10");
    drive(op(0, 0, 0, 0, 0), op(0, 0, 0, 0, 0), "R10");
    drive(op(0, 0, 0, 0, 0), op(0, 0, 0, 0, 0), "R10");
    // R11: read meets a write on the other port
    drive(idle(), op(1, 1, 0, 201, 'h022), "R11");
    drive(op(1, 1, 0, 201, 'h155), op(0, 0, 0, 0, 0), "R11");
    drive(idle(), op(0, 0, 0, 0, 0), "R11");
    drive(idle(), op(0, 0, 0, 0, 0), "R11");

    // R3: pipelined timing
    set_mode(1'b1);
    for (int i = 0; i < 6; i++)
      drive(op(0, i == 0, i != 0, 0, 0), op(0, i == 0, i != 0, 100, 0), "R3");
    drive(op(1, 1, 0, 300, 'h0C3), op(0, 1, 0, 1023, 0), "R3");
    drive(op(0, 1, 0, 300, 0), op(0, 0, 1, 0, 0), "R3");
    // R9: reactivation after deselection
    drive(idle(), op(0, 1, 0, 7, 0), "R9");
    drive(idle(), op(0, 0, 1, 7, 0), "R9");
    drive(op(0, 1, 0, 10, 0), idle(), "R9");
    drive(op(0, 0, 1, 0, 0), idle(), "R9");
    drive(idle(), idle(), "R9");
    drive(idle(), idle(), "R9");

    // R2: back to flow-through
    set_mode(1'b0);
    drive(op(0, 1, 0, 12, 0), op(0, 1, 0, 300, 0), "R2");
    drive(op(0, 0, 1, 0, 0), idle(), "R2");
    drive(idle(), idle(), "R2");
    repeat (3) @(negedge clk);
    done = 1'b1;
    report();
  end

endmodule